// File: doc/BRIEF.md
# Parallel Poll Response Unit

This unit produces a device's answer to a parallel poll on a byte-wide shared data bus. A software-writable enable mask selects which bits of the device's 8-bit status byte count towards a single local status bit. That bit is 1 when any selected status bit is set.

The bus controller configures the unit in two steps. First it sends a configure strobe. Then it sends one configuration byte, which carries a response sense and a 3-bit line number. While the poll-active input is high, the unit drives a 1 onto the configured data line if the local status bit equals the configured sense. All other lines stay undriven. This lets several devices share one line in wired-OR or wired-AND fashion.

Outputs are registered. A change on the status, the poll-active input or the mask shows at the outputs one clock edge later. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `ppoll_resp_unit`

## Requirements
- R1: The local status bit equals the OR-reduction of (enable mask AND status byte). It is 0 when that AND is zero.
- R2: A write pulse loads the 8-bit mask, and the new value appears on the read port after the next clock edge. Without a write pulse, the mask keeps its value whatever the write data is.
- R3: A configuration byte is accepted only when it is the first byte after a configure strobe and its bits 6:4 equal 3'b110. Bit 7 has no effect. The first byte after a strobe uses up the strobe, whether it is accepted or not.
- R4: A byte whose bits 6:4 differ from 3'b110 is discarded, and so is a byte with no pending strobe. In both cases the previous configuration stays in force.
- R5: Bit 3 of an accepted byte is the sense. The unit responds only when the local status bit equals the sense. Otherwise all lines stay undriven.
- R6: Bits 2:0 of an accepted byte, value n, select data line n-1 modulo 8. So 1 selects bit 0, 7 selects bit 6 and 0 selects bit 7.
- R7: With mask 8'h40 and configuration byte 8'h69, the poll pattern is 8'h00 when status bit 6 is 0 and 8'h01 when it is 1.
- R8: At most one line enable is high. A responding line is driven to 1, and a line whose enable is low carries data 0.
- R9: From reset until the first accepted configuration byte, the unit never drives any line.
- R10: The enables and data are 0 in every cycle that follows a cycle with poll-active low. When poll-active is high, the response reflects the inputs of the previous cycle.
- R11: Right after reset the mask reads 0 and all data and enable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 8 | Device status byte |
| mask_wr_i | input | 1 | Enable-mask write strobe |
| mask_wdata_i | input | 8 | Enable-mask write data |
| mask_rdata_o | output | 8 | Enable-mask read value |
| cfg_arm_i | input | 1 | Configure strobe from the controller |
| cfg_byte_vld_i | input | 1 | Configuration byte valid |
| cfg_byte_i | input | 8 | Configuration byte |
| poll_active_i | input | 1 | Parallel poll in progress |
| poll_data_o | output | 8 | Data value per bus line |
| poll_oe_o | output | 8 | Drive enable per bus line |

## Verification
The bench builds the unit with its default 8-bit status width, which keeps every input space small enough to sweep in full. It writes all 256 mask values and reads each one back. It sends every one of the 256 configuration bytes after a strobe and probes each result with several mask and status pairs, so every sense, every line number and every rejected tag pattern is covered. It also sweeps all 256 status values under both senses. Strobe misuse, polls before the first configuration and idle-poll cycles are run as directed sequences against a bench-side model of the rules.

// File: rtl/ppoll_pkg.sv
package ppoll_pkg;

  // Configuration byte layout is fixed by the bus protocol.
  localparam int CFG_W   = 8;
  localparam int POS_W   = 3;
  localparam int LINES   = 1 << POS_W;
  localparam logic [CFG_W-1:0] TAG_MASK = 8'h70;  // bits 6:4 checked, bit 7 dropped
  localparam logic [CFG_W-1:0] TAG_VAL  = 8'h60;  // 3'b110 in bits 6:4
  localparam int SENSE_BIT = 3;

  typedef struct packed {
    logic             valid;
    logic             sense;
    logic [POS_W-1:0] pos;
  } ppoll_cfg_t;

endpackage

// File: rtl/ppoll_rst_sync.sv
module ppoll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ppoll_ist_gen.sv
module ppoll_ist_gen #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask_o,
  output logic              ist_o
);

  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign ist_o  = |(mask_q & status);

  // R2: mask holds without a write pulse
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

  // R2: a write pulse lands on the next edge
  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mask_q == $past(wdata));

endmodule

// File: rtl/ppoll_cfg_dec.sv
module ppoll_cfg_dec
  import ppoll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             byte_vld_i,
  input  logic [CFG_W-1:0] byte_i,
  output ppoll_cfg_t       cfg_o
);

  logic       armed_q;
  logic       armed_d;
  logic       take;
  logic       tag_ok;
  ppoll_cfg_t cfg_q;
  ppoll_cfg_t cfg_d;

  assign tag_ok = (byte_i & TAG_MASK) == TAG_VAL;
  assign take   = armed_q && byte_vld_i && !arm_i;

  always_comb begin
    armed_d = armed_q;
    if (arm_i)           armed_d = 1'b1;
    else if (byte_vld_i) armed_d = 1'b0;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (take && tag_ok) begin
      cfg_d.valid = 1'b1;
      cfg_d.sense = byte_i[SENSE_BIT];
      cfg_d.pos   = byte_i[POS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R4: a byte with a wrong tag never alters the configuration
  a_r4_bad_tag_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && byte_i[6:4] != 3'b110) |=> $stable(cfg_q));

  // R4: no pending strobe means no change
  a_r4_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> $stable(cfg_q));

  // R3: an accepted byte sets sense and line number
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (take && byte_i[6:4] == 3'b110) |=>
      cfg_q.valid && cfg_q.sense == $past(byte_i[3]) && cfg_q.pos == $past(byte_i[2:0]));

  // R9: once configured, stays configured
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.valid |=> cfg_q.valid);

endmodule

// File: rtl/ppoll_line_drv.sv
module ppoll_line_drv
  import ppoll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_active_i,
  input  logic             ist_i,
  input  ppoll_cfg_t       cfg_i,
  output logic [LINES-1:0] data_o,
  output logic [LINES-1:0] oe_o
);

  logic [POS_W-1:0] tgt;
  logic [LINES-1:0] sel;
  logic             respond;
  logic [LINES-1:0] oe_d;
  logic [LINES-1:0] data_d;
  logic [LINES-1:0] oe_q;
  logic [LINES-1:0] data_q;

  // Line numbers count from 1; the field wraps so 0 means the top line.
  assign tgt = cfg_i.pos - POS_W'(1);

  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign sel[g] = (tgt == POS_W'(g));
  end

  assign respond = poll_active_i && cfg_i.valid && (ist_i == cfg_i.sense);

  always_comb begin
    oe_d   = '0;
    data_d = '0;
    if (respond) begin
      oe_d   = sel;
      data_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      data_q <= '0;
    end else begin
      oe_q   <= oe_d;
      data_q <= data_d;
    end
  end

  assign oe_o   = oe_q;
  assign data_o = data_q;

  // R10: silent after an idle cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_active_i |=> oe_q == '0);

  // R8: one line at most
  a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe_q));

  // R8: no data on undriven lines
  a_r8_data_in_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q & ~oe_q) == '0);

  // R9: unconfigured unit stays silent
  a_r9_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.valid |=> oe_q == '0);

  // R5: sense mismatch gives no drive
  a_r5_sense_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_i != cfg_i.sense) |=> oe_q == '0);

endmodule

// File: rtl/ppoll_resp_unit.sv
module ppoll_resp_unit
  import ppoll_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  output logic [STAT_W-1:0] mask_rdata_o,
  input  logic              cfg_arm_i,
  input  logic              cfg_byte_vld_i,
  input  logic [CFG_W-1:0]  cfg_byte_i,
  input  logic              poll_active_i,
  output logic [LINES-1:0]  poll_data_o,
  output logic [LINES-1:0]  poll_oe_o
);

  logic       rst_n_s;
  logic       ist;
  ppoll_cfg_t cfg;

  ppoll_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ppoll_ist_gen #(.STAT_W(STAT_W)) u_ist (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (mask_wr_i),
    .wdata  (mask_wdata_i),
    .status (status_i),
    .mask_o (mask_rdata_o),
    .ist_o  (ist)
  );

  ppoll_cfg_dec u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .arm_i      (cfg_arm_i),
    .byte_vld_i (cfg_byte_vld_i),
    .byte_i     (cfg_byte_i),
    .cfg_o      (cfg)
  );

  ppoll_line_drv u_drv (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .poll_active_i (poll_active_i),
    .ist_i         (ist),
    .cfg_i         (cfg),
    .data_o        (poll_data_o),
    .oe_o          (poll_oe_o)
  );

  // R1: the response follows the masked status under sense 1
  a_r1_ist_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    (poll_active_i && cfg.valid && cfg.sense && (mask_rdata_o & status_i) == '0)
      |=> poll_oe_o == '0);

endmodule

// File: tb/ppoll_resp_unit_bench.sv
module ppoll_resp_unit_bench;

  logic       clk;
  logic       rst_n;
  logic [7:0] status_i;
  logic       mask_wr_i;
  logic [7:0] mask_wdata_i;
  logic [7:0] mask_rdata_o;
  logic       cfg_arm_i;
  logic       cfg_byte_vld_i;
  logic [7:0] cfg_byte_i;
  logic       poll_active_i;
  logic [7:0] poll_data_o;
  logic [7:0] poll_oe_o;

  int n_chk;
  int n_fail;

  // bench-side model of configuration state
  bit       m_armed;
  bit       m_valid;
  bit       m_sense;
  bit [2:0] m_pos;
  bit [7:0] m_mask;

  ppoll_resp_unit #(.STAT_W(8)) u_ppoll_resp_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .status_i       (status_i),
    .mask_wr_i      (mask_wr_i),
    .mask_wdata_i   (mask_wdata_i),
    .mask_rdata_o   (mask_rdata_o),
    .cfg_arm_i      (cfg_arm_i),
    .cfg_byte_vld_i (cfg_byte_vld_i),
    .cfg_byte_i     (cfg_byte_i),
    .poll_active_i  (poll_active_i),
    .poll_data_o    (poll_data_o),
    .poll_oe_o      (poll_oe_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  function automatic bit [7:0] exp_pat(input bit act, input bit [7:0] st);
    bit ist;
    int line;
    ist  = |(m_mask & st);
    line = (m_pos == 3'd0) ? 7 : int'(m_pos) - 1;
    if (act && m_valid && (ist == m_sense)) return 8'h01 << line;
    return 8'h00;
  endfunction

  task automatic write_mask(input bit [7:0] v);
    @(negedge clk);
    mask_wr_i = 1'b1; mask_wdata_i = v;
    @(negedge clk);
    mask_wr_i = 1'b0; mask_wdata_i = ~v;
    m_mask = v;
  endtask

  task automatic send_cfg(input bit arm, input bit [7:0] b);
    if (arm) begin
      @(negedge clk);
      cfg_arm_i = 1'b1;
      m_armed = 1'b1;
    end
    @(negedge clk);
    cfg_arm_i = 1'b0; cfg_byte_vld_i = 1'b1; cfg_byte_i = b;
    if (m_armed && b[6:4] == 3'b110) begin
      m_valid = 1'b1; m_sense = b[3]; m_pos = b[2:0];
    end
    m_armed = 1'b0;
    @(negedge clk);
    cfg_byte_vld_i = 1'b0;
  endtask

  task automatic poll(input string req, input bit act, input bit [7:0] st);
    bit [7:0] e;
    @(negedge clk);
    status_i = st; poll_active_i = act;
    @(negedge clk);
    e = exp_pat(act, st);
    chk(req, "oe", poll_oe_o, e);
    chk(req, "data", poll_data_o, e);
    poll_active_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit [7:0] masks [4];
    bit [7:0] stats [4];
    n_chk = 0; n_fail = 0;
    m_armed = 0; m_valid = 0; m_sense = 0; m_pos = 0; m_mask = 0;
    rst_n = 1'b0; status_i = 0; mask_wr_i = 0; mask_wdata_i = 0;
    cfg_arm_i = 0; cfg_byte_vld_i = 0; cfg_byte_i = 0; poll_active_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", "mask", mask_rdata_o, 8'h00);
    chk("R11", "oe", poll_oe_o, 8'h00);
    chk("R11", "data", poll_data_o, 8'h00);

    // R9: no response before configuration, both ist values
    write_mask(8'hFF);
    poll("R9", 1'b1, 8'hFF);
    poll("R9", 1'b1, 8'h00);
    send_cfg(1'b1, 8'h51);  // wrong tag: still unconfigured
    poll("R9", 1'b1, 8'h00);
    poll("R9", 1'b1, 8'hFF);

    // R2: mask write/read and hold, all values
    for (int v = 0; v < 256; v++) begin
      write_mask(8'(v));
      chk("R2", "readback", mask_rdata_o, 8'(v));
      @(negedge clk);
      chk("R2", "hold", mask_rdata_o, 8'(v));
    end

    // R7: worked example
    write_mask(8'h40);
    send_cfg(1'b1, 8'h69);
    poll("R7", 1'b1, 8'h00);
    chk("R7", "rqs0", poll_data_o, 8'h00);
    poll("R7", 1'b1, 8'h40);
    chk("R7", "rqs1", poll_data_o, 8'h01);
    poll("R7", 1'b1, 8'hBF);

    // R10: idle poll stays silent although status matches
    poll("R10", 1'b0, 8'h40);

    // R3 R5 R6 R4: every configuration byte after a strobe
    masks = '{8'h00, 8'h40, 8'h40, 8'h81};
    stats = '{8'hFF, 8'h40, 8'hBF, 8'h01};
    for (int b = 0; b < 256; b++) begin
      send_cfg(1'b1, 8'(b));
      for (int k = 0; k < 4; k++) begin
        write_mask(masks[k]);
        poll("R3_R5_R6", 1'b1, stats[k]);
      end
    end

    // R4: byte with no strobe is discarded
    send_cfg(1'b0, 8'h60);
    write_mask(8'h01);
    poll("R4", 1'b1, 8'h01);
    poll("R4", 1'b1, 8'h00);

    // R3: strobe consumed by a rejected byte
    send_cfg(1'b1, 8'h12);
    send_cfg(1'b0, 8'h6A);
    poll("R3", 1'b1, 8'h01);
    poll("R3", 1'b1, 8'h00);

    // R3: bit 7 set still accepted
    send_cfg(1'b1, 8'hE3);
    poll("R3", 1'b1, 8'h00);
    poll("R3", 1'b1, 8'h01);

    // R1 R8: status sweep under both senses
    write_mask(8'h5A);
    send_cfg(1'b1, 8'h69);
    for (int s = 0; s < 256; s++) poll("R1_R8", 1'b1, 8'(s));
    send_cfg(1'b1, 8'h64);
    for (int s = 0; s < 256; s++) poll("R1_R5", 1'b1, 8'(s));

    // R10: idle again after active
    poll("R10", 1'b1, 8'h00);
    poll("R10", 1'b0, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule